// File: doc/BRIEF.md
# Packed Double-to-Int32 Converter

This unit turns one 128-bit operand carrying two binary64 floating-point numbers into one 64-bit word carrying two signed 32-bit two's-complement integers. Each lane is handled by its own converter. The 2-bit rounding selector applies to both lanes. The low binary64 value becomes the low integer and the high binary64 value becomes the high integer. The result and the two exception flags appear one clock after the operand is presented.

A lane is invalid when it holds a NaN or an infinity, or when its rounded value falls outside the signed 32-bit range. If invalid exceptions are masked, an invalid lane yields the indefinite integer 0x80000000. If they are unmasked and any lane is invalid, the unit raises a fault and leaves its destination register untouched. A lane that converts validly but loses information raises the precision flag. Both flags are the OR of the two lanes.

Top module: `pd2i_convert`

## Requirements
- R1: Source bits [63:0] produce destination bits [31:0], and source bits [127:64] produce destination bits [63:32]. Each lane is converted independently of the other.
- R2: The rounding selector chooses the rounding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, and 2'b11 truncates toward zero.
- R3: The range check is applied to the rounded value. A rounded value above 2147483647 or below -2147483648 makes the lane invalid. With the invalid mask at 1, that lane returns 32'h80000000.
- R4: A NaN (exponent field all ones, fraction nonzero) or an infinity of either sign makes the lane invalid. With the mask at 1, that lane returns 32'h80000000.
- R5: A lane that is valid and whose rounded value differs from the exact input raises precision. Zero of either sign converts to 0 with no flag. A nonzero subnormal converts to 0, -1 or +1 according to the rounding, and raises precision. An invalid lane does not raise precision.
- R6: The invalid flag is the OR of the two lanes' invalid conditions, and the precision flag is the OR of the two lanes' precision conditions.
- R7: When the mask is 0 and at least one lane is invalid, the fault output is 1 and the destination keeps its previous value. Otherwise the fault output is 0.
- R8: Results, flags and the output valid signal appear on the clock edge after the edge that accepts an operand. When no operand was accepted, the output valid, both flags and the fault are 0 and the destination holds its value.
- R9: After reset the destination, both flags, the fault and the output valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand is presented this cycle |
| src | input | 128 | Two packed binary64 values |
| rnd_mode | input | 2 | Rounding selector (see R2) |
| inv_mask | input | 1 | 1 = invalid masked, substitute indefinite |
| out_valid | output | 1 | Result and flags belong to an accepted operand |
| dst | output | 64 | Two packed signed 32-bit integers |
| flag_inv | output | 1 | Invalid raised by either lane |
| flag_pe | output | 1 | Precision (inexact) raised by either lane |
| fault | output | 1 | Unmasked invalid; destination not written |

## Verification
The assertions check on every cycle the properties that involve timing and control: the one-cycle valid handshake, that idle cycles carry no flags and hold the destination, that a fault only comes with invalid and freezes the destination, that a masked operand never faults, and that a masked invalid result contains the indefinite pattern. The arithmetic cannot be checked that way. Correct rounding in each mode, the post-rounding range boundary around ±2^31, subnormal and signed-zero handling, and the exact precision flag are shown only by the bench sweep. That sweep compares every pair of boundary values under all four rounding modes and both mask settings against a real-number reference.

// File: rtl/pd2i_pkg.sv
package pd2i_pkg;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_t;

endpackage

// File: rtl/pd2i_lane.sv
module pd2i_lane
    import pd2i_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] fp_in,
    input  rnd_t                 mode,
    output logic [INT_W-1:0]     int_out,
    output logic                 invalid,
    output logic                 inexact
);
    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int SIG_W = MAN_W + 1;
    localparam int EW2   = EXP_W + 2;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    localparam logic signed [EW2-1:0] BIAS_E = EW2'(BIAS);
    localparam logic signed [EW2-1:0] E_LIM  = EW2'(INT_W);
    localparam logic signed [EW2-1:0] E_M1   = '1;
    localparam logic [SIG_W-1:0]      ONE    = SIG_W'(1);
    localparam logic [SIG_W:0]        NEG_MAX = (SIG_W+1)'(1) << (INT_W - 1);
    localparam logic [SIG_W:0]        POS_MAX = NEG_MAX - (SIG_W+1)'(1);
    localparam logic [INT_W-1:0]      INDEF   = {1'b1, {(INT_W-1){1'b0}}};

    logic                  sgn;
    logic [EXP_W-1:0]      ex;
    logic [MAN_W-1:0]      fr;
    logic [SIG_W-1:0]      sig;
    logic [SIG_W-1:0]      mag;
    logic [SIG_W-1:0]      half;
    logic signed [EW2-1:0] e_unb;
    logic                  g_bit;
    logic                  s_bit;
    logic                  special;
    logic                  huge;
    logic                  inc;
    logic                  range_bad;
    logic [SIG_W:0]        mag_r;
    logic [INT_W-1:0]      mag_lo;
    int                    sh;

    // Split the operand and find the integer part plus guard and sticky bits.
    always_comb begin
        sgn     = fp_in[FP_W-1];
        ex      = fp_in[FP_W-2 -: EXP_W];
        fr      = fp_in[MAN_W-1:0];
        sig     = {1'b1, fr};
        e_unb   = $signed({2'b00, ex}) - BIAS_E;
        mag     = '0;
        half    = '0;
        g_bit   = 1'b0;
        s_bit   = 1'b0;
        special = 1'b0;
        huge    = 1'b0;
        sh      = 0;
        if (ex == '1) begin
            special = 1'b1;
        end else if (ex == '0) begin
            s_bit = |fr;
        end else if (e_unb >= E_LIM) begin
            huge = 1'b1;
        end else if (e_unb == E_M1) begin
            g_bit = 1'b1;
            s_bit = |fr;
        end else if (e_unb < E_M1) begin
            s_bit = 1'b1;
        end else begin
            sh    = MAN_W - int'(e_unb);
            mag   = sig >> sh;
            half  = ONE << (sh - 1);
            g_bit = |(sig & half);
            s_bit = |(sig & (half - ONE));
        end
    end

    // Rounding increment chosen by the selected mode.
    always_comb begin
        unique case (mode)
            RND_NEAR: inc = g_bit & (s_bit | mag[0]);
            RND_DOWN: inc = sgn & (g_bit | s_bit);
            RND_UP:   inc = ~sgn & (g_bit | s_bit);
            RND_ZERO: inc = 1'b0;
        endcase
    end

    // Range check after rounding, then sign and substitution.
    always_comb begin
        mag_r     = {1'b0, mag} + {{SIG_W{1'b0}}, inc};
        range_bad = sgn ? (mag_r > NEG_MAX) : (mag_r > POS_MAX);
        invalid   = special | huge | range_bad;
        mag_lo    = mag_r[INT_W-1:0];
        int_out   = invalid ? INDEF : (sgn ? -mag_lo : mag_lo);
        inexact   = ~invalid & (g_bit | s_bit);
    end
endmodule

// File: rtl/pd2i_convert.sv
module pd2i_convert
    import pd2i_pkg::*;
#(
    parameter int LANES = 2,
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [LANES*(1+EXP_W+MAN_W)-1:0] src,
    input  logic [1:0]                       rnd_mode,
    input  logic                             inv_mask,
    output logic                             out_valid,
    output logic [LANES*INT_W-1:0]           dst,
    output logic                             flag_inv,
    output logic                             flag_pe,
    output logic                             fault
);
    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int DST_W = LANES * INT_W;

    logic [DST_W-1:0] lane_res;
    logic [LANES-1:0] lane_inv;
    logic [LANES-1:0] lane_pe;
    logic [DST_W-1:0] dst_nxt;
    logic             take_fault;
    logic             any_inv;
    logic             any_pe;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        pd2i_lane #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W),
            .INT_W (INT_W)
        ) u_lane (
            .fp_in   (src[gi*FP_W +: FP_W]),
            .mode    (rnd_t'(rnd_mode)),
            .int_out (lane_res[gi*INT_W +: INT_W]),
            .invalid (lane_inv[gi]),
            .inexact (lane_pe[gi])
        );
    end

    always_comb begin
        any_inv    = |lane_inv;
        any_pe     = |lane_pe;
        take_fault = in_valid & any_inv & ~inv_mask;
        dst_nxt    = (in_valid && !take_fault) ? lane_res : dst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst       <= '0;
            flag_inv  <= 1'b0;
            flag_pe   <= 1'b0;
            fault     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            dst       <= dst_nxt;
            flag_inv  <= in_valid & any_inv;
            flag_pe   <= in_valid & any_pe;
            fault     <= take_fault;
        end
    end
endmodule

// File: rtl/pd2i_convert_chk.sv
module pd2i_convert_chk #(
    parameter int DST_W = 64,
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             inv_mask,
    input logic             out_valid,
    input logic [DST_W-1:0] dst,
    input logic             flag_inv,
    input logic             flag_pe,
    input logic             fault
);
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!flag_inv && !flag_pe && !fault && $stable(dst)));

    a_r7_fault_needs_inv: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> flag_inv);

    a_r7_fault_holds_dst: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(dst));

    a_r3_masked_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_mask) |=> !fault);

    a_r3_masked_indef: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_inv && !fault) |-> (dst[INT_W-1:0] == INDEF || dst[DST_W-1 -: INT_W] == INDEF));
endmodule

bind pd2i_convert pd2i_convert_chk #(
    .DST_W (DST_W),
    .INT_W (INT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .inv_mask  (inv_mask),
    .out_valid (out_valid),
    .dst       (dst),
    .flag_inv  (flag_inv),
    .flag_pe   (flag_pe),
    .fault     (fault)
);

// File: tb/pd2i_convert_bench.sv
module pd2i_convert_bench;
    localparam int NV = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src = '0;
    logic [1:0]   rnd_mode = 2'b00;
    logic         inv_mask = 1'b1;
    logic         out_valid;
    logic [63:0]  dst;
    logic         flag_inv;
    logic         flag_pe;
    logic         fault;

    int checks = 0;
    int errors = 0;
    logic [63:0] vec [NV];
    logic [63:0] exp_dst = '0;

    always #2 clk = ~clk;

    pd2i_convert u_pd2i_convert (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src       (src),
        .rnd_mode  (rnd_mode),
        .inv_mask  (inv_mask),
        .out_valid (out_valid),
        .dst       (dst),
        .flag_inv  (flag_inv),
        .flag_pe   (flag_pe),
        .fault     (fault)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Real-number reference for one lane.
    task automatic ref_lane(input logic [63:0] b, input logic [1:0] m,
                            output logic [31:0] res, output logic inv,
                            output logic pe, output logic nan_inf);
        real r, f, d, t;
        nan_inf = (b[62:52] == 11'h7FF);
        res = 32'h8000_0000;
        inv = 1'b1;
        pe = 1'b0;
        if (!nan_inf) begin
            r = $bitstoreal(b);
            f = $floor(r);
            case (m)
                2'b00: begin
                    d = r - f;
                    if (d > 0.5) t = f + 1.0;
                    else if (d < 0.5) t = f;
                    else t = (f / 2.0 == $floor(f / 2.0)) ? f : f + 1.0;
                end
                2'b01: t = f;
                2'b10: t = $ceil(r);
                default: t = (r >= 0.0) ? f : -$floor(-r);
            endcase
            if (t <= 2147483647.0 && t >= -2147483648.0) begin
                inv = 1'b0;
                res = 32'($rtoi(t));
                pe = (t != r);
            end
        end
    endtask

    task automatic run_op(input logic [63:0] lo, input logic [63:0] hi,
                          input logic [1:0] m, input logic mk);
        logic [31:0] r0, r1;
        logic i0, i1, p0, p1, n0, n1, ef;
        string t0, t1;
        ref_lane(lo, m, r0, i0, p0, n0);
        ref_lane(hi, m, r1, i1, p1, n1);
        ef = (i0 | i1) & ~mk;
        if (!ef) exp_dst = {r1, r0};
        src = {hi, lo};
        rnd_mode = m;
        inv_mask = mk;
        in_valid = 1'b1;
        @(negedge clk);
        t0 = n0 ? "R1/R4 lane0" : (i0 ? "R1/R3 lane0" : "R1/R2 lane0");
        t1 = n1 ? "R1/R4 lane1" : (i1 ? "R1/R3 lane1" : "R1/R2 lane1");
        check("R8 out_valid", 64'(out_valid), 64'd1);
        check(ef ? "R7 lane0 held" : t0, 64'(dst[31:0]), 64'(exp_dst[31:0]));
        check(ef ? "R7 lane1 held" : t1, 64'(dst[63:32]), 64'(exp_dst[63:32]));
        check("R6 flag_inv", 64'(flag_inv), 64'(i0 | i1));
        check("R5/R6 flag_pe", 64'(flag_pe), 64'(p0 | p1));
        check("R7 fault", 64'(fault), 64'(ef));
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec[0]  = 64'h0000_0000_0000_0000;
        vec[1]  = 64'h8000_0000_0000_0000;
        vec[2]  = 64'h0000_0000_0000_0001;
        vec[3]  = 64'h8000_0000_0000_0001;
        vec[4]  = 64'h7FF8_0000_0000_0000;
        vec[5]  = 64'h7FF0_0000_0000_0001;
        vec[6]  = 64'h7FF0_0000_0000_0000;
        vec[7]  = 64'hFFF0_0000_0000_0000;
        vec[8]  = $realtobits(2147483647.5);
        vec[9]  = $realtobits(2147483647.4);
        vec[10] = $realtobits(2147483647.0);
        vec[11] = $realtobits(2147483646.5);
        vec[12] = $realtobits(-2147483648.4);
        vec[13] = $realtobits(-2147483648.5);
        vec[14] = $realtobits(-2147483648.6);
        vec[15] = $realtobits(-2147483648.0);
        vec[16] = $realtobits(0.5);
        vec[17] = $realtobits(1.5);
        vec[18] = $realtobits(2.5);
        vec[19] = $realtobits(-0.5);
        vec[20] = $realtobits(-1.5);
        vec[21] = $realtobits(4294967296.0);
        vec[22] = $realtobits(1.0e300);
        vec[23] = $realtobits(-1.0e300);
        vec[24] = $realtobits(123456.789);
        vec[25] = $realtobits(-7.25);
        vec[26] = $realtobits(0.49999999999);
        vec[27] = $realtobits(2147483648.0);

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid", 64'(out_valid), 64'd0);
        check("R9 dst", dst, 64'd0);
        check("R9 flags", {62'd0, flag_inv, flag_pe}, 64'd0);
        check("R9 fault", 64'(fault), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int mk = 1; mk >= 0; mk--) begin
            for (int m = 0; m < 4; m++) begin
                for (int i = 0; i < NV; i++) begin
                    for (int j = 0; j < NV; j++) begin
                        run_op(vec[i], vec[j], 2'(m), 1'(mk));
                    end
                end
                // R8: idle cycle keeps the destination and clears flags
                in_valid = 1'b0;
                src = {vec[4], vec[5]};
                @(negedge clk);
                check("R8 idle out_valid", 64'(out_valid), 64'd0);
                check("R8 idle dst", dst, exp_dst);
                check("R8 idle flags", {61'd0, flag_inv, flag_pe, fault}, 64'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule